// File: doc/BRIEF.md
# Alternator Fault Lamp Controller

This block decides when a charging-system warning lamp is lit. It takes digital status flags from analog comparators: battery undervoltage, battery overvoltage, rotor phase frequency below a low threshold, rotor frequency above an upper threshold, and load dump. It also takes an external lamp-gate request. From these it produces a lamp drive enable and an ignition-sample strobe. Each fault source is debounced over a programmable number of regulation frames before it can light the lamp, and the same count must pass before it releases the lamp.

While the lamp is requested, the drive is interrupted for a short window in every polling period. This lets the ignition-sense input be read through the lamp path, and the sample strobe fires in the middle of that window. When ignition is off the block stays in standby, with the lamp dark and all debounce history cleared. After ignition turns on, fault qualification waits out a start delay.

Top module: `lamp_fault_ctrl`

## Requirements
- R1: While `ign_on` is low, `lamp_on` and `ign_sample` are 0 from the next clock on. All debounce state is cleared, so after ignition returns a fault must qualify again from zero.
- R2: For `START_CYC` cycles after `ign_on` goes high, no internal fault is qualified, and the lamp stays off unless it is overridden.
- R3: Undervoltage (`uv_flag`=1) is a fault only while `rotor_fast`=1. Undervoltage with `rotor_fast`=0 never lights the lamp.
- R4: Overvoltage (`ov_flag`=1) is a fault on its own.
- R5: A rotor below the low threshold (`rotor_slow`=1) is a fault on its own.
- R6: A fault lights the lamp only after it has been sampled present on `deb_frames` consecutive frame ticks, with one tick every `FRAME_DIV` cycles. It releases the lamp only after it has been sampled absent for the same count. A shorter pulse is ignored. A value of 0 acts as 1.
- R7: With `ign_on`=1 and `load_dump`=0, `ext_gate`=1 requests the lamp from the next clock. This holds regardless of the fault status and of the start delay.
- R8: `load_dump`=1 forces `lamp_on` to 0 from the next clock, and this overrides both faults and `ext_gate`.
- R9: While the lamp is requested, each `POLL_PERIOD`-cycle period ends with exactly `POLL_WIN` consecutive cycles of `lamp_on`=0. The period count starts when the request begins.
- R10: `ign_sample` is a single-cycle pulse, issued once per polling period. It falls on the (`POLL_WIN`/2+1)-th cycle of the off-window, with `lamp_on`=0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ign_on | input | 1 | Ignition sensed on |
| uv_flag | input | 1 | Battery undervoltage |
| ov_flag | input | 1 | Battery overvoltage |
| rotor_slow | input | 1 | Rotor frequency below low threshold |
| rotor_fast | input | 1 | Rotor frequency above upper threshold |
| load_dump | input | 1 | Load dump in progress |
| ext_gate | input | 1 | External lamp request |
| deb_frames | input | DEB_W | Debounce length in frames |
| lamp_on | output | 1 | Lamp drive enable |
| ign_sample | output | 1 | Ignition sample strobe |

## Verification
Load dump and the lamp request, whether it comes from the external override or from a qualified fault, can arrive in the same cycle. The bench raises `load_dump` while `ext_gate` is high and an overvoltage is already qualified. It expects the lamp to be dark on the very next clock and to stay dark for the whole dump. The poll strobe can also coincide with an active request. For that case the bench tracks where each strobe falls within the off-window and requires the lamp to be off at every strobe.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    localparam int NUM_FAULTS = 3;

    typedef enum logic [1:0] {
        FLT_UNDER = 2'd0,
        FLT_OVER  = 2'd1,
        FLT_STALL = 2'd2
    } fault_idx_e;

    typedef struct packed {
        logic stall;
        logic over;
        logic under;
    } fault_vec_t;

    function automatic fault_vec_t raw_faults(
        input logic uv,
        input logic ov,
        input logic slow,
        input logic fast
    );
        fault_vec_t f;
        f.under = uv & fast;
        f.over  = ov;
        f.stall = slow;
        return f;
    endfunction

endpackage

// File: rtl/lfc_ign_delay.sv
module lfc_ign_delay #(
    parameter int START_CYC = 50500
) (
    input  logic clk,
    input  logic rst,
    input  logic ign_on,
    output logic ready
);
    localparam int DW = $clog2(START_CYC + 1);
    localparam logic [DW-1:0] LAST = DW'(START_CYC);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !ign_on) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = ign_on && (cnt == LAST);
endmodule

// File: rtl/lfc_frame_timer.sv
module lfc_frame_timer #(
    parameter int FRAME_DIV = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int FW = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1;
    localparam logic [FW-1:0] TOP = FW'(FRAME_DIV - 1);

    logic [FW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == TOP) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == TOP);
endmodule

// File: rtl/lfc_debounce.sv
module lfc_debounce #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic          raw,
    input  logic [CW-1:0] limit,
    output logic          qual
);
    logic [CW-1:0] cnt;
    logic [CW:0]   nxt;
    logic [CW:0]   lim_eff;

    always_comb begin
        nxt     = {1'b0, cnt} + 1'b1;
        lim_eff = (limit == '0) ? (CW+1)'(1) : {1'b0, limit};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (tick) begin
            if (raw != qual) begin
                if (nxt >= lim_eff) begin
                    qual <= raw;
                    cnt  <= '0;
                end else begin
                    cnt <= nxt[CW-1:0];
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/lfc_poll.sv
module lfc_poll #(
    parameter int POLL_PERIOD = 4096,
    parameter int POLL_WIN    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic window,
    output logic strobe
);
    localparam int PW = $clog2(POLL_PERIOD);
    localparam logic [PW-1:0] TOP       = PW'(POLL_PERIOD - 1);
    localparam logic [PW-1:0] WIN_START = PW'(POLL_PERIOD - POLL_WIN);
    localparam logic [PW-1:0] STROBE_AT = PW'(POLL_PERIOD - POLL_WIN + POLL_WIN / 2);

    logic [PW-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pc <= '0;
        end else if (pc == TOP) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    assign window = active && (pc >= WIN_START);
    assign strobe = active && (pc == STROBE_AT);
endmodule

// File: rtl/lamp_fault_ctrl.sv
module lamp_fault_ctrl #(
    parameter int FRAME_DIV   = 256,
    parameter int START_CYC   = 50500,
    parameter int POLL_PERIOD = 4096,
    parameter int POLL_WIN    = 16,
    parameter int DEB_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ign_on,
    input  logic             uv_flag,
    input  logic             ov_flag,
    input  logic             rotor_slow,
    input  logic             rotor_fast,
    input  logic             load_dump,
    input  logic             ext_gate,
    input  logic [DEB_W-1:0] deb_frames,
    output logic             lamp_on,
    output logic             ign_sample
);
    import lfc_pkg::*;

    logic                  ready;
    logic                  frame_tick;
    fault_vec_t            raw;
    logic [NUM_FAULTS-1:0] raw_bits;
    logic [NUM_FAULTS-1:0] fault_q;
    logic                  lamp_req;
    logic                  poll_window;
    logic                  poll_strobe;

    lfc_ign_delay #(.START_CYC(START_CYC)) u_delay (
        .clk(clk), .rst(rst), .ign_on(ign_on), .ready(ready)
    );

    lfc_frame_timer #(.FRAME_DIV(FRAME_DIV)) u_frame (
        .clk(clk), .rst(rst), .en(ready), .tick(frame_tick)
    );

    assign raw      = raw_faults(uv_flag, ov_flag, rotor_slow, rotor_fast);
    assign raw_bits = raw;

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_deb
        lfc_debounce #(.CW(DEB_W)) u_deb (
            .clk(clk), .rst(rst), .clr(!ready), .tick(frame_tick),
            .raw(raw_bits[i]), .limit(deb_frames), .qual(fault_q[i])
        );
    end

    assign lamp_req = ign_on && (ext_gate || (|fault_q));

    lfc_poll #(.POLL_PERIOD(POLL_PERIOD), .POLL_WIN(POLL_WIN)) u_poll (
        .clk(clk), .rst(rst), .active(lamp_req),
        .window(poll_window), .strobe(poll_strobe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lamp_on    <= 1'b0;
            ign_sample <= 1'b0;
        end else begin
            lamp_on    <= lamp_req && !load_dump && !poll_window;
            ign_sample <= poll_strobe;
        end
    end
endmodule

// File: rtl/lamp_fault_ctrl_chk.sv
module lamp_fault_ctrl_chk #(
    parameter int NF = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          ign_on,
    input logic          load_dump,
    input logic          ext_gate,
    input logic          lamp_on,
    input logic          ign_sample,
    input logic          ready,
    input logic          frame_tick,
    input logic          poll_window,
    input logic [NF-1:0] fault_q
);
    a_r1_standby_dark: assert property (@(posedge clk) disable iff (rst)
        !ign_on |=> (!lamp_on && !ign_sample));

    a_r2_no_qual_in_delay: assert property (@(posedge clk) disable iff (rst)
        !ready |=> (fault_q == '0));

    a_r6_change_on_tick: assert property (@(posedge clk) disable iff (rst)
        ((fault_q != $past(fault_q)) && $past(ready) && !$past(rst)) |-> $past(frame_tick));

    a_r7_override_on: assert property (@(posedge clk) disable iff (rst)
        (ign_on && ext_gate && !load_dump) |=> (lamp_on || $past(poll_window)));

    a_r8_dump_dark: assert property (@(posedge clk) disable iff (rst)
        load_dump |=> !lamp_on);

    a_r10_sample_dark: assert property (@(posedge clk) disable iff (rst)
        ign_sample |-> !lamp_on);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ign_sample |=> !ign_sample);
endmodule

bind lamp_fault_ctrl lamp_fault_ctrl_chk #(.NF(lfc_pkg::NUM_FAULTS)) u_chk (
    .clk(clk), .rst(rst), .ign_on(ign_on), .load_dump(load_dump),
    .ext_gate(ext_gate), .lamp_on(lamp_on), .ign_sample(ign_sample),
    .ready(ready), .frame_tick(frame_tick), .poll_window(poll_window),
    .fault_q(fault_q)
);

// File: tb/tb_lamp_fault_ctrl.sv
`timescale 1ns/1ps
module tb_lamp_fault_ctrl;
    localparam int FD = 8;
    localparam int SC = 40;
    localparam int PP = 64;
    localparam int PWIN = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ign_on = 0, uv_flag = 0, ov_flag = 0, rotor_slow = 0, rotor_fast = 0;
    logic load_dump = 0, ext_gate = 0;
    logic [3:0] deb_frames = 4'd1;
    logic lamp_on, ign_sample;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lamp_fault_ctrl #(.FRAME_DIV(FD), .START_CYC(SC), .POLL_PERIOD(PP),
                      .POLL_WIN(PWIN), .DEB_W(4)) dut (
        .clk(clk), .rst(rst), .ign_on(ign_on), .uv_flag(uv_flag),
        .ov_flag(ov_flag), .rotor_slow(rotor_slow), .rotor_fast(rotor_fast),
        .load_dump(load_dump), .ext_gate(ext_gate), .deb_frames(deb_frames),
        .lamp_on(lamp_on), .ign_sample(ign_sample)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // count cycles with lamp on over n cycles
    task automatic count_on(input int n, output int on_cnt);
        on_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (lamp_on) on_cnt++;
        end
    endtask

    task automatic clear_all();
        uv_flag = 0; ov_flag = 0; rotor_slow = 0; rotor_fast = 0;
        ext_gate = 0; load_dump = 0;
        cyc(16 * FD + 4);
    endtask

    task automatic t_reset();
        cyc(3);
        check("R1 reset lamp", lamp_on, 0);
        check("R1 reset sample", ign_sample, 0);
        rst = 0;
        cyc(2);
        check("R1 standby lamp", lamp_on, 0);
    endtask

    task automatic t_delay();
        deb_frames = 4'd1;
        ov_flag = 1;
        ign_on = 1;
        cyc(SC / 2);
        check("R2 lamp off in start delay", lamp_on, 0);
        cyc(SC / 2 + 20);
        check("R4 overvoltage lights lamp", lamp_on, 1);
        clear_all();
        check("R4 overvoltage released", lamp_on, 0);
    endtask

    task automatic t_uv();
        int c;
        uv_flag = 1; rotor_fast = 0;
        count_on(40, c);
        check("R3 undervoltage without fast rotor", c, 0);
        rotor_fast = 1;
        cyc(3 * FD + 4);
        check("R3 undervoltage with fast rotor", lamp_on, 1);
        clear_all();
    endtask

    task automatic t_slow();
        rotor_slow = 1;
        cyc(3 * FD + 4);
        check("R5 slow rotor lights lamp", lamp_on, 1);
        clear_all();
        check("R5 slow rotor released", lamp_on, 0);
    endtask

    task automatic t_deb();
        int c;
        deb_frames = 4'd3;
        ov_flag = 1;
        cyc(12);
        ov_flag = 0;
        count_on(40, c);
        check("R6 short pulse ignored", c, 0);
        ov_flag = 1;
        cyc(12);
        check("R6 not yet qualified", lamp_on, 0);
        cyc(16);
        check("R6 qualified after count", lamp_on, 1);
        ov_flag = 0;
        count_on(12, c);
        check("R6 still held during clear count", (c > 0) ? 1 : 0, 1);
        cyc(24);
        count_on(PP + 6, c);
        check("R6 released after clear count", c, 0);
        deb_frames = 4'd0;
        ov_flag = 1;
        count_on(FD + 4, c);
        check("R6 zero count acts as one", (c > 0) ? 1 : 0, 1);
        clear_all();
        deb_frames = 4'd1;
    endtask

    task automatic t_override();
        ext_gate = 1;
        cyc(1);
        check("R7 override lights lamp", lamp_on, 1);
        ext_gate = 0;
        cyc(2);
        check("R7 override released", lamp_on, 0);
    endtask

    task automatic t_dump();
        int c;
        ov_flag = 1;
        ext_gate = 1;
        cyc(3 * FD);
        load_dump = 1;
        cyc(1);
        check("R8 dump forces lamp off", lamp_on, 0);
        count_on(20, c);
        check("R8 dump holds lamp off", c, 0);
        clear_all();
    endtask

    task automatic t_poll();
        int off_cnt, strobes, bad_pos, lit_strobe, run, max_run;
        off_cnt = 0; strobes = 0; bad_pos = 0; lit_strobe = 0; run = 0; max_run = 0;
        ext_gate = 1;
        for (int i = 0; i < 3 * PP; i++) begin
            @(posedge clk); @(negedge clk);
            if (!lamp_on) begin
                off_cnt++; run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
            if (ign_sample) begin
                strobes++;
                if (lamp_on) lit_strobe++;
                if (run != PWIN / 2 + 1) bad_pos++;
            end
        end
        check("R9 off cycles over three periods", off_cnt, 3 * PWIN);
        check("R9 off window length", max_run, PWIN);
        check("R10 one strobe per period", strobes, 3);
        check("R10 strobe inside window middle", bad_pos, 0);
        check("R10 lamp off at strobe", lit_strobe, 0);
        ext_gate = 0;
        cyc(2);
    endtask

    task automatic t_standby();
        int c, s;
        ov_flag = 1;
        cyc(3 * FD);
        check("R1 lamp on before standby", lamp_on, 1);
        ign_on = 0;
        cyc(1);
        check("R1 standby turns lamp off", lamp_on, 0);
        s = 0; c = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); @(negedge clk);
            if (lamp_on) c++;
            if (ign_sample) s++;
        end
        check("R1 standby lamp stays off", c, 0);
        check("R1 standby no strobes", s, 0);
        ign_on = 1;
        cyc(SC / 2);
        check("R1 debounce cleared by standby", lamp_on, 0);
        ext_gate = 1;
        cyc(1);
        check("R7 override during start delay", lamp_on, 1);
        clear_all();
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_delay();
        t_uv();
        t_slow();
        t_deb();
        t_override();
        t_dump();
        t_poll();
        t_standby();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule